// File: doc/BRIEF.md
# Bit Error Injector for a Serial Test Stream

The block sits in a one-bit-per-beat test-pattern path and changes bits as they pass. It flips bits for two reasons. The first is a periodic rate of one flip per 10^n accepted bits, where n runs from 1 to 7 or the rate is off. The second is a single flip on request, and that request comes either from a register strobe or from an external pin, chosen by configuration. On top of both, the whole stream can be inverted.

Data enters and leaves through valid/ready handshakes and passes through one output register. Back-pressure follows these rules. An input beat is accepted in a cycle where `s_valid` and `s_ready` are both high. `s_ready` is high whenever the output register is empty or is being drained in the same cycle (`m_ready` high). While `m_valid` is high and `m_ready` is low, the output bit and its valid flag hold steady. Configuration inputs are plain levels. They are meant to change only while no beat is being accepted, and a new rate setting applies to beats accepted from the cycle after the change.

Top module: `bit_err_inject`

## Requirements
- R1: After reset, `m_valid` is low and `s_ready` is high.
- R2: `s_ready` equals `!m_valid || m_ready`. Each accepted beat appears on `m_data` with `m_valid` high in the next cycle. A stalled output (`m_valid` high, `m_ready` low) keeps `m_valid` high and `m_data` unchanged.
- R3: With no error applied, `m_data` equals the accepted `s_data` when `cfg_invert` is 0, and its complement when `cfg_invert` is 1.
- R4: With `cfg_rate` = n (1 to 7), every 10^n-th accepted beat is flipped, counting from the last change of `cfg_rate`. `cfg_rate` = 0 turns rate flips off.
- R5: The rate count advances only on accepted beats. Stalled or idle cycles do not move it.
- R6: Any change of `cfg_rate` restarts the count, so the first rate flip falls on the 10^n-th beat accepted after the change.
- R7: With `cfg_trig_src` = 0, a cycle with `err_strobe` high arms one error. That error flips the first beat accepted in a later cycle.
- R8: With `cfg_trig_src` = 1, each rising edge of `err_pin` arms exactly one error, after a two-flop synchronizer. A pin held high arms nothing more.
- R9: The trigger source that is not selected has no effect on the output.
- R10: A beat that is both a rate beat and an armed single-error beat is flipped exactly once.
- R11: Several requests that arrive before the next accepted beat merge into one flip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rate | input | 3 | Rate exponent n; 0 = rate flips off |
| cfg_trig_src | input | 1 | Single-error source: 0 = register strobe, 1 = pin |
| cfg_invert | input | 1 | Invert every bit of the stream |
| err_strobe | input | 1 | Register command: one-cycle request for a single error |
| err_pin | input | 1 | Asynchronous external single-error trigger |
| s_valid | input | 1 | Input bit valid |
| s_ready | output | 1 | Block can accept an input bit |
| s_data | input | 1 | Input bit |
| m_valid | output | 1 | Output bit valid |
| m_ready | input | 1 | Downstream accepts the output bit |
| m_data | output | 1 | Output bit after error insertion and inversion |

## Verification
The hardest case to reach is a single error landing on exactly the beat where the rate counter wraps. The bench makes it happen by counting accepted beats itself. It raises the strobe in an idle cycle just before the tenth beat at rate 1, then sends that beat and checks that the bit is flipped once and not twice. The rate sweep goes through every exponent from 1 to 4 at full throughput, and a second rate run uses an irregular `m_ready` and `s_valid` pattern, so the count is shown to advance only on accepted beats.

// File: rtl/bei_pkg.sv
package bei_pkg;

  // Decimal power used to size and fill the rate limits.
  function automatic longint unsigned pow10(input int e);
    longint unsigned v;
    v = 1;
    for (int k = 0; k < e; k++) v = v * 10;
    return v;
  endfunction

  typedef enum logic {
    SRC_REG = 1'b0,
    SRC_PIN = 1'b1
  } trig_src_e;

endpackage

// File: rtl/bei_trig_ctrl.sv
module bei_trig_ctrl
  import bei_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_sel,
  input  logic strobe,
  input  logic pin_async,
  input  logic beat,
  output logic pend
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise;
  logic                   trig;
  logic                   pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign trig = (trig_src_e'(src_sel) == SRC_PIN) ? rise : strobe;

  // A request stays armed until a beat consumes it; new requests merge.
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= trig | (pend_q & ~beat);
  end

  assign pend = pend_q;

  // R8
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && beat && !trig) |=> !pend_q);

endmodule

// File: rtl/bei_rate_gen.sv
module bei_rate_gen
  import bei_pkg::*;
#(
  parameter int MAX_EXP = 7,
  parameter int RATE_W  = 3,
  parameter int CNT_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic              beat,
  output logic              hit
);

  localparam int N_SET = 2 ** RATE_W;

  logic [CNT_W-1:0] lim_tab [N_SET];
  logic [N_SET-1:0] en_vec;
  logic [CNT_W-1:0] cnt_q;
  logic [RATE_W-1:0] rate_q;
  logic [CNT_W-1:0] limit;
  logic             en;
  logic             changed;

  for (genvar g = 0; g < N_SET; g++) begin : g_lim
    if (g >= 1 && g <= MAX_EXP) begin : g_on
      assign lim_tab[g] = CNT_W'(pow10(g) - 1);
      assign en_vec[g]  = 1'b1;
    end else begin : g_off
      assign lim_tab[g] = '0;
      assign en_vec[g]  = 1'b0;
    end
  end

  assign limit   = lim_tab[rate];
  assign en      = en_vec[rate];
  assign changed = (rate != rate_q);
  assign hit     = beat & en & ~changed & (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= '0;
      cnt_q  <= '0;
    end else begin
      rate_q <= rate;
      if (changed)          cnt_q <= '0;
      else if (hit)         cnt_q <= '0;
      else if (beat && en)  cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !changed |-> (cnt_q <= limit));

  // R5
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat && !changed) |=> $stable(cnt_q));

endmodule

// File: rtl/bei_out_stage.sv
module bei_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  output logic s_ready,
  input  logic s_data,
  input  logic flip,
  input  logic invert,
  output logic beat,
  output logic m_valid,
  input  logic m_ready,
  output logic m_data
);

  logic vld_q;
  logic dat_q;

  assign s_ready = ~vld_q | m_ready;
  assign beat    = s_valid & s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= 1'b0;
    end else begin
      if (beat) begin
        vld_q <= 1'b1;
        dat_q <= s_data ^ flip ^ invert;
      end else if (m_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign m_valid = vld_q;
  assign m_data  = dat_q;

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

endmodule

// File: rtl/bit_err_inject.sv
module bit_err_inject
  import bei_pkg::*;
#(
  parameter int MAX_EXP     = 7,
  parameter int SYNC_STAGES = 2,
  localparam int RATE_W     = $clog2(MAX_EXP + 1),
  localparam int CNT_W      = $clog2(pow10(MAX_EXP))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              cfg_trig_src,
  input  logic              cfg_invert,
  input  logic              err_strobe,
  input  logic              err_pin,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_data
);

  logic beat;
  logic rate_hit;
  logic single;
  logic flip;

  bei_trig_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_sel   (cfg_trig_src),
    .strobe    (err_strobe),
    .pin_async (err_pin),
    .beat      (beat),
    .pend      (single)
  );

  bei_rate_gen #(.MAX_EXP(MAX_EXP), .RATE_W(RATE_W), .CNT_W(CNT_W)) u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .rate  (cfg_rate),
    .beat  (beat),
    .hit   (rate_hit)
  );

  // Either cause flips the bit; coinciding causes still flip it once.
  assign flip = rate_hit | single;

  bei_out_stage u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_data  (s_data),
    .flip    (flip),
    .invert  (cfg_invert),
    .beat    (beat),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data)
  );

endmodule

// File: tb/test_bit_err_inject.sv
module test_bit_err_inject;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_rate = '0;
  logic       cfg_trig_src = 1'b0;
  logic       cfg_invert = 1'b0;
  logic       err_strobe = 1'b0;
  logic       err_pin = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic       s_data = 1'b0;
  logic       m_valid;
  logic       m_ready = 1'b0;
  logic       m_data;

  int  errors = 0;
  int  checks = 0;
  bit  exp_q[$];
  int  bcnt = 0;
  bit  pend = 0;
  int  mrate = 0;
  bit  msrc = 0;
  bit  minv = 0;
  int  kseq = 0;
  string cur_req = "R1";
  bit  done = 0;

  bit_err_inject i_bit_err_inject (
    .clk(clk), .rst_n(rst_n), .cfg_rate(cfg_rate), .cfg_trig_src(cfg_trig_src),
    .cfg_invert(cfg_invert), .err_strobe(err_strobe), .err_pin(err_pin),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int p10(input int e);
    int v = 1;
    for (int k = 0; k < e; k++) v = v * 10;
    return v;
  endfunction

  function automatic bit pat(input int k);
    return bit'(((k * 37) >> 3) & 1) ^ bit'(k % 5 == 0);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, then account for both handshakes.
  task automatic cycle(input bit sv, input bit mr, input bit st);
    bit sd, hit, e, got;
    @(negedge clk);
    sd = pat(kseq);
    s_valid = sv; s_data = sd; m_ready = mr; err_strobe = st;
    #1;
    if (m_valid && m_ready) begin
      if (exp_q.size() == 0) check(cur_req, 1, 0);
      else begin
        e = exp_q.pop_front();
        got = m_data;
        check(cur_req, int'(got), int'(e));
      end
    end
    if (sv && s_ready) begin
      kseq++;
      bcnt++;
      hit = (mrate != 0) && (bcnt % p10(mrate) == 0);
      exp_q.push_back(sd ^ minv ^ (hit | pend));
      pend = 0;
    end
    if (st && !msrc) pend = 1;
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 20) begin
      cycle(0, 1, 0);
      guard++;
    end
    check({cur_req, " drain"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic set_cfg(input int r, input bit src, input bit inv);
    drain();
    @(negedge clk);
    s_valid = 0; err_strobe = 0;
    cfg_rate = 3'(r); cfg_trig_src = src; cfg_invert = inv;
    if (r != mrate) bcnt = 0;
    mrate = r; msrc = src; minv = inv;
    cycle(0, 1, 0);
    cycle(0, 1, 0);
  endtask

  task automatic beats(input int n);
    for (int i = 0; i < n; i++) cycle(1, 1, 0);
  endtask

  task automatic pin_pulse(input int hold);
    @(negedge clk);
    err_pin = 1;
    for (int i = 0; i < hold; i++) cycle(0, 1, 0);
    @(negedge clk);
    err_pin = 0;
    for (int i = 0; i < 4; i++) cycle(0, 1, 0);
    if (msrc) pend = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    check("R1 m_valid", int'(m_valid), 0);
    check("R1 s_ready", int'(s_ready), 1);

    // R3: plain and inverted pass-through
    cur_req = "R3";
    set_cfg(0, 0, 0); beats(40);
    set_cfg(0, 0, 1); beats(40);

    // R4: sweep every exponent the run time allows
    cur_req = "R4";
    for (int n = 1; n <= 4; n++) begin
      set_cfg(n, 0, n % 2);
      beats(2 * p10(n) + 3);
    end

    // R5 / R2: irregular stalls, count advances only on accepted beats
    cur_req = "R5";
    set_cfg(1, 0, 0);
    for (int i = 0; i < 120; i++) cycle(bit'(i % 4 != 1), bit'(i % 3 != 0), 0);
    // R2: stalled output holds
    cur_req = "R2";
    cycle(1, 0, 0);
    @(negedge clk); s_valid = 0; m_ready = 0; #1;
    check("R2 s_ready while stalled", int'(s_ready), 0);
    check("R2 m_valid while stalled", int'(m_valid), 1);
    drain();

    // R6: change of rate restarts the count
    cur_req = "R6";
    set_cfg(2, 0, 0); beats(57);
    set_cfg(1, 0, 0); beats(25);

    // R7: register strobe arms one error
    cur_req = "R7";
    set_cfg(0, 0, 0); beats(3);
    cycle(0, 1, 1); beats(5);
    // R7: strobe in a beat cycle flips the following beat
    cycle(1, 1, 1); beats(3);

    // R11: two requests merge into one flip
    cur_req = "R11";
    cycle(0, 1, 1); cycle(0, 1, 1); beats(4);

    // R8: pin edges, one error each, long high level arms only one
    cur_req = "R8";
    set_cfg(0, 1, 0);
    pin_pulse(1); beats(4);
    pin_pulse(30); beats(4);
    pin_pulse(2); beats(3);

    // R9: unselected sources ignored
    cur_req = "R9";
    cycle(0, 1, 1); beats(4);
    set_cfg(0, 0, 1);
    pin_pulse(3); beats(4);

    // R10: single error on the rate beat flips once
    cur_req = "R10";
    set_cfg(1, 0, 0); beats(9);
    cycle(0, 1, 1); beats(3);
    set_cfg(1, 0, 1); beats(19);
    cycle(0, 1, 1); beats(2);
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule